// File: doc/BRIEF.md
# UART Low-Power Sleep Controller

This block decides when a UART's baud clock domain may be put to sleep and when it must be woken. It watches the receive line, the transmit FIFO and shift-register empty flags, the vector of pending interrupt sources, a host write strobe into the transmit FIFO and a software sleep-enable bit. Its single output, `sleepOut`, is meant to drive an external clock-gating cell for the baud domain.

The UART is "quiet" when five conditions hold together. The enable bit must be set and the receive line must be high. Both transmit storage elements must be empty. No host write may be in progress. No interrupt source may be pending except the transmit-holding-empty source, which is masked out on purpose because an empty transmitter is the normal state of a UART that is asleep. Sleep is entered only after the quiet state has held for one full character time, counted in baud ticks. Any break in quiet drops the sleep output combinationally in the same cycle. The controller then needs another full character time of quiet before it sleeps again.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset (`rstN` low) is asserted, `sleepOut` is 0. After reset the character-time count starts from zero.
- R2: `sleepOut` rises only after the quiet state has held for CHAR_TICKS = BITS_PER_CHAR*TICKS_PER_BIT baud ticks. The tick that completes the count is sampled at a clock edge, and `sleepOut` goes high one clock edge after that.
- R3: Interrupt bit THR_IDX (default 1) of `irqPending` is the transmit-holding-empty source. It neither blocks sleep entry nor wakes the block.
- R4: While asleep, a low level on `rxLine` (a falling edge of the idle line) clears `sleepOut` in the same cycle.
- R5: While asleep, a high `txWrite` clears `sleepOut` in the same cycle.
- R6: While asleep, any set bit of `irqPending` other than THR_IDX clears `sleepOut` in the same cycle.
- R7: While asleep, `txFifoEmpty` low, `txShiftEmpty` low or `sleepEn` low clears `sleepOut` in the same cycle.
- R8: While awake, any cycle that is not quiet restarts the character-time count from zero.
- R9: After a wake, `sleepOut` stays low until a fresh full CHAR_TICKS of quiet baud ticks has been counted.
- R10: Only cycles with `baudTick` high advance the count. With ticks on alternate cycles, entry takes twice as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle baud rate tick |
| rxLine | input | 1 | Receive serial line, high when idle |
| txFifoEmpty | input | 1 | Transmit FIFO empty flag |
| txShiftEmpty | input | 1 | Transmit shift register empty flag |
| txWrite | input | 1 | Host write strobe into the transmit FIFO |
| sleepEn | input | 1 | Software sleep enable |
| irqPending | input | IRQ_W | Pending interrupt sources, bit THR_IDX is transmit-holding-empty |
| sleepOut | output | 1 | Sleep request to the baud-domain clock gate |

## Verification
Wake results (R4 to R7) are due in the same cycle as the disturbing input. The bench drives inputs on the falling edge and compares `sleepOut` one time unit later, before the next rising edge. Entry (R2, R9, R10) is due one rising edge after the edge that counts the last tick. The bench's reference model advances its count and sleep flag at each rising edge from the inputs it drove, so every cycle compares against the state that edge produced. Directed entry checks also count rising edges explicitly: CHAR_TICKS+1 edges with a tick every cycle, and 2*CHAR_TICKS edges with a tick every other cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } slpState_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } slpStrobe_t;

endpackage

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int CHAR_TICKS = 160,
  parameter int IRQ_W      = 6,
  parameter int THR_IDX    = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  slpStrobe_t       strobe,
  input  logic             rxLine,
  input  logic             txFifoEmpty,
  input  logic             txShiftEmpty,
  input  logic             txWrite,
  input  logic             sleepEn,
  input  logic [IRQ_W-1:0] irqPending,
  output logic             quiet,
  output logic             charDone
);

  localparam int CNT_W = $clog2(CHAR_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CHAR_TICKS);

  logic [IRQ_W-1:0] irqMask;
  logic [CNT_W-1:0] idleCnt;
  logic             otherIrq;

  // mask keeps every source except transmit-holding-empty
  for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
    if (i == THR_IDX) begin : g_thr
      assign irqMask[i] = 1'b0;
    end else begin : g_src
      assign irqMask[i] = 1'b1;
    end
  end

  assign otherIrq = |(irqPending & irqMask);

  assign quiet = sleepEn & rxLine & txFifoEmpty & txShiftEmpty
               & ~txWrite & ~otherIrq;

  assign charDone = (idleCnt == CNT_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.cntClear) begin
      idleCnt <= '0;
    end else if (strobe.cntInc && !charDone) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/slp_control.sv
module slp_control
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       quiet,
  input  logic       charDone,
  output slpStrobe_t strobe,
  output logic       sleepOut
);

  slpState_e state, stateNxt;

  always_comb begin
    stateNxt        = state;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    unique case (state)
      ST_AWAKE: begin
        if (!quiet) begin
          strobe.cntClear = 1'b1;
        end else if (charDone) begin
          stateNxt = ST_ASLEEP;
        end else begin
          strobe.cntInc = baudTick;
        end
      end
      ST_ASLEEP: begin
        if (!quiet) begin
          stateNxt        = ST_AWAKE;
          strobe.cntClear = 1'b1;
        end
      end
      default: stateNxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= stateNxt;
  end

  // wake path is combinational so the gate opens in the disturbing cycle
  assign sleepOut = (state == ST_ASLEEP) & quiet;

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import slp_pkg::*;
#(
  parameter int BITS_PER_CHAR = 10,
  parameter int TICKS_PER_BIT = 16,
  parameter int IRQ_W         = 6,
  parameter int THR_IDX       = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             rxLine,
  input  logic             txFifoEmpty,
  input  logic             txShiftEmpty,
  input  logic             txWrite,
  input  logic             sleepEn,
  input  logic [IRQ_W-1:0] irqPending,
  output logic             sleepOut
);

  localparam int CHAR_TICKS = BITS_PER_CHAR * TICKS_PER_BIT;

  slpStrobe_t strobe;
  logic       quiet;
  logic       charDone;

  slp_datapath #(
    .CHAR_TICKS(CHAR_TICKS),
    .IRQ_W     (IRQ_W),
    .THR_IDX   (THR_IDX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxLine      (rxLine),
    .txFifoEmpty (txFifoEmpty),
    .txShiftEmpty(txShiftEmpty),
    .txWrite     (txWrite),
    .sleepEn     (sleepEn),
    .irqPending  (irqPending),
    .quiet       (quiet),
    .charDone    (charDone)
  );

  slp_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .quiet   (quiet),
    .charDone(charDone),
    .strobe  (strobe),
    .sleepOut(sleepOut)
  );

endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
  parameter int BITS_PER_CHAR = 10,
  parameter int TICKS_PER_BIT = 16,
  parameter int IRQ_W         = 6,
  parameter int THR_IDX       = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             baudTick,
  input logic             rxLine,
  input logic             txFifoEmpty,
  input logic             txShiftEmpty,
  input logic             txWrite,
  input logic             sleepEn,
  input logic [IRQ_W-1:0] irqPending,
  input logic             sleepOut
);

  localparam int LIM = BITS_PER_CHAR * TICKS_PER_BIT;
  localparam int RW  = $clog2(LIM + 1);

  logic [IRQ_W-1:0] otherBits;
  logic             calm;
  logic [RW-1:0]    calmRun;

  always_comb begin
    otherBits          = irqPending;
    otherBits[THR_IDX] = 1'b0;
  end

  assign calm = sleepEn & rxLine & txFifoEmpty & txShiftEmpty & ~txWrite
              & (otherBits == '0);

  // saturating tally of quiet baud ticks, replaces a long delay window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            calmRun <= '0;
    else if (!calm)                       calmRun <= '0;
    else if (baudTick && calmRun != RW'(LIM)) calmRun <= calmRun + 1'b1;
  end

  always_comb begin
    if (!rstN) p_reset_awake_r1: assert (!sleepOut);
  end

  p_entry_needs_char_r2: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |-> (calmRun == RW'(LIM)));

  p_rx_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxLine |-> !sleepOut);

  p_write_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |-> !sleepOut);

  p_irq_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (otherBits != '0) |-> !sleepOut);

  p_busy_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!txFifoEmpty || !txShiftEmpty || !sleepEn) |-> !sleepOut);

  p_rewake_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!calm) |=> !sleepOut);

endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(
  .BITS_PER_CHAR(BITS_PER_CHAR),
  .TICKS_PER_BIT(TICKS_PER_BIT),
  .IRQ_W        (IRQ_W),
  .THR_IDX      (THR_IDX)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .baudTick    (baudTick),
  .rxLine      (rxLine),
  .txFifoEmpty (txFifoEmpty),
  .txShiftEmpty(txShiftEmpty),
  .txWrite     (txWrite),
  .sleepEn     (sleepEn),
  .irqPending  (irqPending),
  .sleepOut    (sleepOut)
);

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;

  localparam int BPC   = 3;
  localparam int TPB   = 4;
  localparam int LIM   = BPC * TPB;
  localparam int IRQ_W = 6;
  localparam int THR   = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic rxLine = 1'b1;
  logic txFifoEmpty = 1'b1;
  logic txShiftEmpty = 1'b1;
  logic txWrite = 1'b0;
  logic sleepEn = 1'b1;
  logic [IRQ_W-1:0] irqPending = '0;
  logic sleepOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mSleep = 0;
  int mCnt = 0;

  always #2.5 clk = ~clk;

  uart_sleep_ctrl #(
    .BITS_PER_CHAR(BPC), .TICKS_PER_BIT(TPB), .IRQ_W(IRQ_W), .THR_IDX(THR)
  ) dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine),
    .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty), .txWrite(txWrite),
    .sleepEn(sleepEn), .irqPending(irqPending), .sleepOut(sleepOut)
  );

  function automatic bit quietNow();
    logic [IRQ_W-1:0] o;
    o = irqPending;
    o[THR] = 1'b0;
    return sleepEn & rxLine & txFifoEmpty & txShiftEmpty & ~txWrite & (o == '0);
  endfunction

  function automatic bit expOut();
    return mSleep & quietNow();
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: sleepOut=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // called just after inputs are driven at a falling edge
  task automatic cyc(input string tag);
    bit q;
    #1;
    chk(tag, sleepOut, expOut());
    q = quietNow();
    @(posedge clk);
    if (mSleep) begin
      if (!q) begin mSleep = 0; mCnt = 0; end
    end else if (!q) mCnt = 0;
    else if (mCnt == LIM) mSleep = 1;
    else if (baudTick) mCnt++;
    @(negedge clk);
  endtask

  task automatic calmAll();
    rxLine = 1; txFifoEmpty = 1; txShiftEmpty = 1; txWrite = 0;
    sleepEn = 1; irqPending = '0;
  endtask

  // tick every cycle until asleep, returns edges used
  task automatic enterSleep(input string tag, output int edges);
    edges = 0;
    baudTick = 1;
    while (!mSleep && edges < 4 * LIM) begin
      cyc(tag);
      edges++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int edges;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", sleepOut, 1'b0);
    @(negedge clk);
    rstN = 1;

    // R1/R2: exact entry timing from a cleared count
    enterSleep("R2", edges);
    total++;
    if (edges != LIM + 1) begin
      bad++;
      $display("FAIL R1/R2: entry edges=%0d expected=%0d", edges, LIM + 1);
    end
    cyc("R2 asleep");

    // R3: transmit-holding-empty source ignored while asleep
    irqPending[THR] = 1; cyc("R3 thr while asleep");
    chk("R3 still asleep", sleepOut, 1'b1);

    // R4: rx falling edge wakes in the same cycle
    rxLine = 0; #1 chk("R4 same cycle", sleepOut, 1'b0); #0;
    cyc("R4"); rxLine = 1;
    // R9: full character again, with THR pending (R3 entry)
    enterSleep("R9", edges);
    total++;
    if (edges != LIM + 1) begin
      bad++;
      $display("FAIL R9/R3: reentry edges=%0d expected=%0d", edges, LIM + 1);
    end

    txWrite = 1; cyc("R5 write wake"); txWrite = 0;
    enterSleep("R6 prep", edges);
    irqPending[0] = 1; cyc("R6 irq wake"); irqPending[0] = 0;
    enterSleep("R7 prep", edges);
    txFifoEmpty = 0; cyc("R7 fifo wake"); txFifoEmpty = 1;
    enterSleep("R7 prep", edges);
    txShiftEmpty = 0; cyc("R7 shift wake"); txShiftEmpty = 1;
    enterSleep("R7 prep", edges);
    sleepEn = 0; cyc("R7 enable wake"); sleepEn = 1;

    // R8: break half way restarts count
    baudTick = 1;
    for (int i = 0; i < LIM / 2; i++) cyc("R8 partial");
    rxLine = 0; cyc("R8 break"); rxLine = 1;
    enterSleep("R8", edges);
    total++;
    if (edges != LIM + 1) begin
      bad++;
      $display("FAIL R8: edges after break=%0d expected=%0d", edges, LIM + 1);
    end

    // R10: ticks on alternate cycles
    sleepEn = 0; cyc("R10 wake"); sleepEn = 1;
    edges = 0;
    while (!mSleep && edges < 8 * LIM) begin
      baudTick = edges[0] ? 1'b0 : 1'b1;
      cyc("R10");
      edges++;
    end
    total++;
    if (edges != 2 * LIM) begin
      bad++;
      $display("FAIL R10: edges=%0d expected=%0d", edges, 2 * LIM);
    end
    chk("R10 asleep", sleepOut, 1'b1);

    // constrained random: mostly quiet, rare disturbances
    for (int n = 0; n < 20000; n++) begin
      calmAll();
      baudTick = ($urandom % 3) != 0;
      irqPending[THR] = $urandom % 2;
      if (($urandom % 30) == 0) begin
        case ($urandom % 6)
          0: rxLine = 0;
          1: txWrite = 1;
          2: txFifoEmpty = 0;
          3: txShiftEmpty = 0;
          4: sleepEn = 0;
          default: irqPending[($urandom % 2) ? 0 : IRQ_W - 1] = 1;
        endcase
      end
      cyc(mSleep ? "R4-R7 random wake" : "R8/R9 random entry");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule